// File: doc/BRIEF.md
# Small-Page Address Translator with Three-Entry LRU Cache

This block maps an 8-bit byte virtual address to a 7-bit physical address. A page is 16 bytes, so the low 4 bits pass through unchanged. The high 4 bits select the virtual page. Physical memory holds 8 frames of 16 bytes. A fully associative cache of three recent translations answers most lookups in the cycle the request is made.

When a lookup misses, a walker fetches one byte from a page table stored in the same physical memory. The table starts at a frame-aligned base that software can load. If the entry is usable, the walker installs it in the translation cache and evicts the least recently used entry. If the entry is not usable, the walker reports a page fault. Handling the fault is left to an outside agent, which updates the table and retries.

Two counters record lookups and hits.

Top module: `vtlb_xlate`

## Requirements
- R1: A completed translation gives `respPaddr = {frame[2:0], vaddr[3:0]}`. The page number is `vaddr[7:4]`.
- R2: When a request is accepted while idle and its page is cached, `respDone` is high in that same cycle with the translation. No memory read is made.
- R3: A request that misses raises `busy` from the next cycle.
- R3 (continued): While `busy` is high, `memRdEn` stays high and `memRdAddr = {tableBase, 4'b0000} + vpn` (modulo 128). This holds until the cycle `memRdValid` is high.
- R4: A table entry is usable when bit 7 is 1 and bits 6:3 are 0. Its frame is in bits 2:0.
- R4 (continued): A usable entry gives `respDone=1` and `pageFault=0` in the cycle `memRdValid` is high. The page is then cached, so a repeat request hits.
- R5: An unusable entry gives `respDone=1` together with `pageFault=1`. The cache contents and recency order are left unchanged.
- R6: The cache holds three entries. A refill into a full cache evicts the least recently used entry. A hit makes its entry the most recent.
- R7: A refilled entry becomes the most recent. A refill goes into an empty slot when one exists.
- R8: `flushAll` invalidates every entry and restores the initial recency order. When it coincides with a refill, the flush wins.
- R9: `lookupCount` counts accepted requests. `hitCount` counts accepted requests that hit. Both are 16 bits wide and wrap.
- R10: `reqValid` while `busy` is ignored. The request is not counted and the walk's address is not changed.
- R11: `baseWe` loads `baseFrame` into the table base register. Later walks read from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 8 | Virtual byte address |
| flushAll | input | 1 | Invalidate all cached translations |
| baseWe | input | 1 | Load page table base |
| baseFrame | input | 3 | Frame holding the page table |
| respDone | output | 1 | Translation finished this cycle |
| respPaddr | output | 7 | Physical byte address |
| pageFault | output | 1 | Page not resident (valid with respDone) |
| busy | output | 1 | Walk in progress |
| memRdEn | output | 1 | Page table read request |
| memRdAddr | output | 7 | Page table entry address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 8 | Page table entry byte |
| hitCount | output | 16 | Hits counted |
| lookupCount | output | 16 | Accepted requests counted |

## Verification
The reference model runs alongside the design on every cycle. It is tried with the following patterns:
- A fill of three pages, followed by a hit and two misses. This separates true LRU eviction from FIFO or fixed-slot replacement.
- A fault on an absent page, followed by re-reads of the three cached pages. This shows that a failed walk leaves the cache alone.
- A malformed entry with reserved bits set. This separates a check of the full entry from a check of bit 7 only.
- Requests driven during a walk. These show whether the walker's captured page or the counters can be disturbed.
- A moved table base, followed by a long random mix of pages. In this mix the bench acts as the fault handler.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  typedef struct packed {
    logic lookupAcc;
    logic hitTouch;
    logic fill;
    logic flush;
    logic walking;
  } ctrlStrb_t;
endpackage

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      flushAll,
  input  logic      hit,
  input  logic      memRdValid,
  input  logic      pteOk,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      memRdEn,
  output logic      respDone,
  output logic      pageFault
);
  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t stateQ, stateD;

  always_comb begin
    strb.walking   = (stateQ == ST_WALK);
    strb.lookupAcc = reqValid && (stateQ == ST_IDLE);
    strb.hitTouch  = strb.lookupAcc && hit;
    strb.fill      = strb.walking && memRdValid && pteOk;
    strb.flush     = flushAll;
    stateD = stateQ;
    if (strb.lookupAcc && !hit) stateD = ST_WALK;
    if (strb.walking && memRdValid) stateD = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy      = strb.walking;
  assign memRdEn   = strb.walking;
  assign respDone  = strb.hitTouch || (strb.walking && memRdValid);
  assign pageFault = strb.walking && memRdValid && !pteOk;

  a_r5_fault_with_done: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> respDone);
  a_r3_hold_until_data: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memRdValid |=> busy);
  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.lookupAcc);
endmodule

// File: rtl/vtlb_datapath.sv
module vtlb_datapath
  import vtlb_pkg::*;
#(
  parameter int VA_W    = 8,
  parameter int PA_W    = 7,
  parameter int OFF_W   = 4,
  parameter int ENTRIES = 3,
  parameter int CNT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrb_t               strb,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic                    baseWe,
  input  logic [PA_W-OFF_W-1:0]   baseFrame,
  input  logic [7:0]              memRdData,
  output logic                    hit,
  output logic                    pteOk,
  output logic [PA_W-1:0]         respPaddr,
  output logic [PA_W-1:0]         memRdAddr,
  output logic [CNT_W-1:0]        hitCount,
  output logic [CNT_W-1:0]        lookupCount
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W = IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PFN_W-1:0]   pfnQ [ENTRIES];
  logic [AGE_W-1:0]   ageQ [ENTRIES];
  logic [VPN_W-1:0]   walkVpnQ;
  logic [OFF_W-1:0]   walkOffQ;
  logic [PFN_W-1:0]   baseQ;

  logic [ENTRIES-1:0] matchVec, mruVec;
  logic [IDX_W-1:0]   hitIdx, victimIdx, touchIdx;
  logic [PFN_W-1:0]   hitPfn;
  logic               touchEn;
  logic [VPN_W-1:0]   reqVpn;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = validQ[g] && (vpnQ[g] == reqVpn);
    assign mruVec[g]   = (ageQ[g] == '0);
  end

  always_comb begin
    hitIdx = '0;
    hitPfn = '0;
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitIdx = IDX_W'(i);
        hitPfn = pfnQ[i];
      end
      if (ageQ[i] == AGE_W'(ENTRIES - 1)) victimIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validQ[i]) victimIdx = IDX_W'(i);
  end

  assign hit      = |matchVec;
  assign pteOk    = memRdData[7] && (memRdData[6:PFN_W] == '0);
  assign touchEn  = (strb.hitTouch || strb.fill) && !strb.flush;
  assign touchIdx = strb.fill ? victimIdx : hitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        pfnQ[i] <= '0;
        ageQ[i] <= AGE_W'(i);
      end
    end else if (strb.flush) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= AGE_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx)          ageQ[i] <= '0;
        else if (ageQ[i] < ageQ[touchIdx])  ageQ[i] <= ageQ[i] + AGE_W'(1);
      end
      if (strb.fill) begin
        validQ[victimIdx] <= 1'b1;
        vpnQ[victimIdx]   <= walkVpnQ;
        pfnQ[victimIdx]   <= memRdData[PFN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walkVpnQ    <= '0;
      walkOffQ    <= '0;
      baseQ       <= '1;
      hitCount    <= '0;
      lookupCount <= '0;
    end else begin
      if (strb.lookupAcc) begin
        walkVpnQ    <= reqVpn;
        walkOffQ    <= reqVaddr[OFF_W-1:0];
        lookupCount <= lookupCount + CNT_W'(1);
      end
      if (strb.hitTouch) hitCount <= hitCount + CNT_W'(1);
      if (baseWe) baseQ <= baseFrame;
    end
  end

  assign memRdAddr = {baseQ, {OFF_W{1'b0}}} + PA_W'(walkVpnQ);
  assign respPaddr = strb.walking ? {memRdData[PFN_W-1:0], walkOffQ}
                                  : {hitPfn, reqVaddr[OFF_W-1:0]};

  a_r6_single_mru: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mruVec) == 1);
  a_r6_unique_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> validQ == '0);
  a_r9_lookup_count: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupAcc |=> lookupCount == $past(lookupCount) + CNT_W'(1));
  a_r10_walk_vpn_stable: assert property (@(posedge clk) disable iff (!rstN)
    strb.walking && $past(strb.walking) |-> $stable(walkVpnQ));
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
  import vtlb_pkg::*;
#(
  parameter int VA_W    = 8,
  parameter int PA_W    = 7,
  parameter int OFF_W   = 4,
  parameter int ENTRIES = 3,
  parameter int CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  flushAll,
  input  logic                  baseWe,
  input  logic [PA_W-OFF_W-1:0] baseFrame,
  output logic                  respDone,
  output logic [PA_W-1:0]       respPaddr,
  output logic                  pageFault,
  output logic                  busy,
  output logic                  memRdEn,
  output logic [PA_W-1:0]       memRdAddr,
  input  logic                  memRdValid,
  input  logic [7:0]            memRdData,
  output logic [CNT_W-1:0]      hitCount,
  output logic [CNT_W-1:0]      lookupCount
);
  ctrlStrb_t strb;
  logic      hit, pteOk;

  vtlb_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .flushAll, .hit, .memRdValid, .pteOk,
    .strb, .busy, .memRdEn, .respDone, .pageFault
  );

  vtlb_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
  ) u_dp (
    .clk, .rstN, .strb, .reqVaddr, .baseWe, .baseFrame, .memRdData,
    .hit, .pteOk, .respPaddr, .memRdAddr, .hitCount, .lookupCount
  );
endmodule

// File: tb/test_vtlb_xlate.sv
module test_vtlb_xlate;
  localparam int CLK_P   = 10;
  localparam int MEM_LAT = 3;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, flushAll = 0, baseWe = 0, memRdValid = 0;
  logic [7:0] reqVaddr = 0, memRdData = 0;
  logic [2:0] baseFrame = 0;
  logic respDone, pageFault, busy, memRdEn;
  logic [6:0] respPaddr, memRdAddr;
  logic [15:0] hitCount, lookupCount;

  vtlb_xlate i_vtlb_xlate (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] mem [128];
  int qVpn[$], qPfn[$];          // front = most recent
  bit mBusy = 0; int mVpn = 0, mOff = 0, mWait = 0, mBase = 7;
  int mLook = 0, mHits = 0, nextFrame = 0;
  bit lastDone, lastFault;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int findVpn(int v);
    foreach (qVpn[i]) if (qVpn[i] == v) return i;
    return -1;
  endfunction

  task automatic cyc(bit rv, logic [7:0] va, bit fl = 0, bit bwe = 0, logic [2:0] bf = 0);
    bit mv, ok, eDone, eFault; int ea, hi, ePa;
    @(negedge clk);
    ea = (mBase * 16 + mVpn) % 128;
    mv = mBusy && (mWait == MEM_LAT - 1);
    reqValid = rv; reqVaddr = va; flushAll = fl; baseWe = bwe; baseFrame = bf;
    memRdValid = mv; memRdData = mem[ea];
    ok = mem[ea][7] && (mem[ea][6:3] == 0);
    #(CLK_P/4);
    hi = -1; eFault = 0; ePa = 0;
    if (!mBusy) begin
      hi = findVpn(va[7:4]);
      eDone = rv && (hi >= 0);
      if (hi >= 0) ePa = qPfn[hi] * 16 + va[3:0];
    end else begin
      eDone = mv; eFault = mv && !ok;
      ePa = mem[ea][2:0] * 16 + mOff;
    end
    chk(busy == mBusy, "R3 busy", busy, mBusy);
    chk(memRdEn == mBusy, "R3 memRdEn", memRdEn, mBusy);
    if (mBusy) chk(memRdAddr == ea[6:0], "R3/R11 memRdAddr", memRdAddr, ea);
    chk(respDone == eDone, "R2/R4 respDone", respDone, eDone);
    chk(pageFault == eFault, "R5/R4 pageFault", pageFault, eFault);
    if (eDone && !eFault) chk(respPaddr == ePa[6:0], "R1 respPaddr", respPaddr, ePa);
    chk(lookupCount == mLook[15:0], "R9/R10 lookupCount", lookupCount, mLook[15:0]);
    chk(hitCount == mHits[15:0], "R9 hitCount", hitCount, mHits[15:0]);
    lastDone = respDone; lastFault = pageFault;
    if (!mBusy && rv) begin
      mLook++;
      if (hi >= 0) begin
        mHits++;
        if (!fl) begin
          int v = qVpn[hi], p = qPfn[hi];
          qVpn.delete(hi); qPfn.delete(hi);
          qVpn.push_front(v); qPfn.push_front(p);
        end
      end else begin
        mBusy = 1; mVpn = va[7:4]; mOff = va[3:0]; mWait = 0;
      end
    end else if (mBusy) begin
      if (mv) begin
        mBusy = 0;
        if (ok && !fl) begin
          qVpn.push_front(mVpn); qPfn.push_front(mem[ea][2:0]);
          if (qVpn.size() > 3) begin void'(qVpn.pop_back()); void'(qPfn.pop_back()); end
        end
      end else mWait++;
    end
    if (fl) begin qVpn.delete(); qPfn.delete(); end
    if (bwe) mBase = bf;
  endtask

  // one access; returns whether it hit in the request cycle; optional noise while busy
  task automatic access(logic [7:0] va, output bit hitNow, input bit noisy = 0);
    cyc(1, va);
    hitNow = lastDone;
    while (mBusy) cyc(noisy, 8'($urandom));
  endtask

  task automatic accessServ(logic [7:0] va);
    bit h;
    access(va, h);
    if (lastFault) begin
      mem[(mBase * 16 + va[7:4]) % 128] = {5'b10000, 3'(nextFrame)};
      nextFrame = (nextFrame + 1) % 7;
      access(va, h);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit h;
    foreach (mem[i]) mem[i] = 8'h00;
    mem[112] = 8'h85; mem[114] = 8'h83; mem[117] = 8'h82; mem[125] = 8'h81;
    mem[124] = 8'hC4;                          // reserved bit set
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state (R3, R9)
    cyc(0, 0);
    // R4, R7: fill pages 0, 2, D (empty slots)
    access(8'h03, h); chk(!h, "R4 first miss", h, 0);
    access(8'h03, h); chk(h,  "R4 refilled page hits", h, 1);
    access(8'h2A, h); access(8'hD1, h);
    // R6: hit 0 -> order 0,D,2 ; 5 evicts 2 ; 2 evicts D
    access(8'h07, h); chk(h,  "R6 hit refreshes", h, 1);
    access(8'h55, h); chk(!h, "R6 new page misses", h, 0);
    access(8'h21, h); chk(!h, "R6 LRU page 2 was evicted", h, 0);
    access(8'h00, h); chk(h,  "R6 MRU page 0 kept", h, 1);
    access(8'hDF, h); chk(!h, "R6 page D evicted", h, 0);
    // cache now D,0,2. R5: fault on page E, cache unchanged
    access(8'hE0, h); chk(lastFault, "R5 fault on absent page", lastFault, 1);
    access(8'hD0, h); chk(h, "R5 D still cached", h, 1);
    access(8'h00, h); chk(h, "R5 0 still cached", h, 1);
    access(8'h20, h); chk(h, "R5 2 still cached", h, 1);
    // R4 reserved bits make entry unusable
    access(8'hC2, h); chk(lastFault, "R4 malformed entry faults", lastFault, 1);
    // R8 flush
    cyc(0, 0, 1);
    access(8'h20, h); chk(!h, "R8 flushed entry misses", h, 0);
    // R8 flush during refill wins
    cyc(1, 8'h01);
    while (mBusy) cyc(0, 0, (mWait == MEM_LAT - 1));
    access(8'h01, h); chk(!h, "R8 flush beats fill", h, 0);
    // R10 requests during walk ignored
    access(8'h5A, h, 1); access(8'hD3, h, 1);
    // R11 move table base to frame 6
    for (int i = 0; i < 16; i++) mem[96 + i] = mem[112 + i];
    cyc(0, 0, 1, 1, 3'd6);
    access(8'h24, h); chk(!lastFault && lastDone, "R11 walk from new base", lastDone, 1);
    // random mix with fault servicing
    for (int n = 0; n < 400; n++) accessServ(8'($urandom));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule